// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a timer with a single free-running main counter and a parameterised set of comparators. Each comparator can raise an interrupt when the counter reaches its programmed expiry value. Software reaches every register through a simple synchronous write port and a combinational read port. Each word-addressed register is 64 bits wide.

Each comparator runs either once (one-shot) or repeatedly (periodic). A periodic comparator holds a hidden period value. On each expiry it adds that period to its expiry value. Both values are loaded through a value-set write sequence. Each interrupt line is either level-type or edge-type. A level line stays high until software clears the matching status bit by writing a one to it. An edge line gives a single-cycle pulse. A force-32 option makes a comparator work on the low half of the counter only.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter reads 0, the counter is stopped, status reads 0, all interrupt outputs are low, and each timer configuration reads 0 except its read-only capability bit.
- R2: The register at word 0 is read-only. Bits [4:0] hold the comparator count minus one, bit 8 is set when the counter is 64 bits wide, and bits [63:32] hold the tick period in femtoseconds. Word 1 is the general configuration, word 2 is status, word 3 is the counter, and timer i uses word 4+2i for its configuration and word 5+2i for its comparator. The timer configuration bits are: [0] interrupt enable, [1] periodic type, [2] level mode, [3] force-32, [4] value-set, [5] periodic-capable (read-only).
- R3: While bit 0 of word 1 is set, the counter advances by one every cycle. While it is clear, the counter holds its value.
- R4: A write to the counter is accepted only while the counter is stopped. While the counter runs, such a write is ignored.
- R5: A one-shot timer expires once and then stays disarmed until its comparator is written again.
- R6: For a periodic timer with value-set set, the first comparator write sets the expiry value and the second sets the period. Value-set then reads back 0.
- R7: On each expiry a periodic timer adds its period to its expiry value. A comparator write in periodic mode with value-set clear changes only the period.
- R8: Status bit i belongs to timer i. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R9: In level mode an expiry sets the status bit. The interrupt output equals that status bit gated by interrupt enable and stays high until the bit is cleared.
- R10: In edge mode an expiry gives an interrupt pulse exactly one cycle long, in the cycle where the counter holds the expiry value. The status bit is not set.
- R11: With interrupt enable clear, a level-mode expiry still sets the status bit, but the interrupt output stays low.
- R12: With force-32 set, the comparator stores only 32 bits, compares against the low 32 counter bits, and reloads modulo 2^32.
- R13: On a timer without periodic capability, writing the periodic type bit has no effect.
- R14: An expiry is detected whenever the counter moves from below the expiry value to at-or-above it, including a load that jumps past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at bus_word |
| bus_word | input | 5 | Register word index |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_word (combinational) |
| irq_o | output | NUM_TMR | One interrupt line per timer |

## Verification
The bench targets the expiry condition at its edges. A counter load that jumps over the expiry value must still fire; a design that tests only for equality would miss it. In force-32 mode, the upper counter half lies above the stored value; a design that compared the full 64 bits would never fire there. The bench restarts the counter below a spent one-shot value; a design that failed to disarm would fire again. The value-set sequence is also checked for a correct readback after reloads; a design that swapped the expiry and period writes, or failed to clear value-set, would return a wrong comparator value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int unsigned FULL_W = 64;
  localparam int unsigned HALF_W = 32;

  localparam logic [4:0] W_CAP = 5'd0;
  localparam logic [4:0] W_GEN = 5'd1;
  localparam logic [4:0] W_STS = 5'd2;
  localparam logic [4:0] W_CNT = 5'd3;

  typedef struct packed {
    logic vset;
    logic f32;
    logic level;
    logic per;
    logic ie;
  } tcfg_t;

  function automatic logic crossed(input logic [FULL_W-1:0] prev_v,
                                   input logic [FULL_W-1:0] next_v,
                                   input logic [FULL_W-1:0] exp_v,
                                   input logic narrow);
    if (narrow)
      return (prev_v[HALF_W-1:0] < exp_v[HALF_W-1:0]) &&
             (next_v[HALF_W-1:0] >= exp_v[HALF_W-1:0]);
    return (prev_v < exp_v) && (next_v >= exp_v);
  endfunction

  function automatic logic [FULL_W-1:0] reload(input logic [FULL_W-1:0] exp_v,
                                               input logic [FULL_W-1:0] per_v,
                                               input logic narrow);
    logic [FULL_W-1:0] sum;
    sum = exp_v + per_v;
    if (narrow) return {{HALF_W{1'b0}}, sum[HALF_W-1:0]};
    return sum;
  endfunction

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             cnt_upd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_upd = 1'b0;
    if (run_q) begin
      cnt_nxt = cnt_q + ONE;
      cnt_upd = 1'b1;
    end else if (ld) begin
      cnt_nxt = ld_val;
      cnt_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (en_wr) run_q <= en_val;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> cnt_q == $past(cnt_q) + ONE); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld) |=> $stable(cnt_q)); // R3
  AST_LD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ld) |=> cnt_q != $past(ld_val) || cnt_q == $past(cnt_q) + ONE); // R4

endmodule

// File: rtl/evt_comparator.sv
module evt_comparator
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter bit          CAN_PER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_old,
  input  logic [CNT_W-1:0] cnt_new,
  input  logic             cnt_upd,
  input  logic             cfg_wr,
  input  logic             cmp_wr,
  input  logic [63:0]      wdata,
  input  logic             sts_clr,
  output logic [63:0]      cfg_rd,
  output logic [63:0]      cmp_rd,
  output logic             status_o,
  output logic             irq_o
);
  localparam logic CAN_BIT = CAN_PER;

  tcfg_t            cfg;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic             armed_q;
  logic             phase_q;
  logic             status_q;
  logic             pulse_q;

  logic             fire;
  logic [63:0]      wv64;
  logic [CNT_W-1:0] wr_val;
  logic [63:0]      next_exp;

  assign fire     = cnt_upd && armed_q &&
                    crossed(64'(cnt_old), 64'(cnt_new), 64'(cmp_q), cfg.f32);
  assign wv64     = cfg.f32 ? {32'h0, wdata[31:0]} : wdata;
  assign wr_val   = wv64[CNT_W-1:0];
  assign next_exp = reload(64'(cmp_q), 64'(per_q), cfg.f32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      cmp_q    <= '0;
      per_q    <= '0;
      armed_q  <= 1'b0;
      phase_q  <= 1'b0;
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q  <= fire && cfg.ie && !cfg.level;
      status_q <= (status_q && !sts_clr) || (fire && cfg.level);
      if (fire) begin
        if (cfg.per) cmp_q <= next_exp[CNT_W-1:0];
        else         armed_q <= 1'b0;
      end
      if (cfg_wr) begin
        cfg.ie    <= wdata[0];
        cfg.per   <= wdata[1] && CAN_BIT;
        cfg.level <= wdata[2];
        cfg.f32   <= wdata[3];
        cfg.vset  <= wdata[4];
        phase_q   <= 1'b0;
      end
      if (cmp_wr) begin
        if (cfg.per) begin
          if (cfg.vset) begin
            if (!phase_q) begin
              cmp_q   <= wr_val;
              armed_q <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              per_q    <= wr_val;
              phase_q  <= 1'b0;
              cfg.vset <= 1'b0;
            end
          end else begin
            per_q <= wr_val;
          end
        end else begin
          cmp_q   <= wr_val;
          armed_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_rd   = {58'h0, CAN_BIT, cfg};
  assign cmp_rd   = 64'(cmp_q);
  assign status_o = status_q;
  assign irq_o    = cfg.level ? (status_q && cfg.ie) : pulse_q;

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg.per && !cmp_wr) |=> !armed_q); // R5
  AST_VSET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cfg_wr && cfg.per && cfg.vset && phase_q) |=> !cfg.vset); // R6
  AST_STS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !fire) |=> !status_q); // R8
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !sts_clr) |=> status_q); // R9
  AST_EDGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(fire)); // R10

  generate
    if (!CAN_PER) begin : g_noper
      AST_NO_PER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !cfg.per); // R13
    end
  endgenerate

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_TMR   = 3,
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned PERIOD_FS = 10_000_000,
  parameter int unsigned PER_CAP   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [4:0]         bus_word,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  output logic [NUM_TMR-1:0] irq_o
);
  localparam logic [4:0]  CNT_FIELD = 5'(NUM_TMR - 1);
  localparam logic        WIDE_BIT  = (CNT_W == 64);
  localparam logic [63:0] CAP_WORD  = {32'(PERIOD_FS), 23'h0, WIDE_BIT, 3'h0, CNT_FIELD};

  logic               run_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_nxt;
  logic               cnt_upd;
  logic [NUM_TMR-1:0] sts_vec;
  logic [63:0]        cfg_rd_a [NUM_TMR];
  logic [63:0]        cmp_rd_a [NUM_TMR];

  logic gen_wr, sts_wr, cnt_wr;
  assign gen_wr = bus_wr && (bus_word == W_GEN);
  assign sts_wr = bus_wr && (bus_word == W_STS);
  assign cnt_wr = bus_wr && (bus_word == W_CNT);

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (gen_wr),
    .en_val  (bus_wdata[0]),
    .ld      (cnt_wr),
    .ld_val  (bus_wdata[CNT_W-1:0]),
    .run_q   (run_q),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .cnt_upd (cnt_upd)
  );

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      localparam logic [4:0] CFG_W = 5'(4 + 2 * g);
      localparam logic [4:0] CMP_W = 5'(5 + 2 * g);
      localparam bit         CAN   = ((PER_CAP >> g) & 1) != 0;

      evt_comparator #(.CNT_W(CNT_W), .CAN_PER(CAN)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_old  (cnt_q),
        .cnt_new  (cnt_nxt),
        .cnt_upd  (cnt_upd),
        .cfg_wr   (bus_wr && (bus_word == CFG_W)),
        .cmp_wr   (bus_wr && (bus_word == CMP_W)),
        .wdata    (bus_wdata),
        .sts_clr  (sts_wr && bus_wdata[g]),
        .cfg_rd   (cfg_rd_a[g]),
        .cmp_rd   (cmp_rd_a[g]),
        .status_o (sts_vec[g]),
        .irq_o    (irq_o[g])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      W_CAP:   bus_rdata = CAP_WORD;
      W_GEN:   bus_rdata = {63'h0, run_q};
      W_STS:   bus_rdata = 64'(sts_vec);
      W_CNT:   bus_rdata = 64'(cnt_q);
      default: begin
        for (int i = 0; i < NUM_TMR; i++) begin
          if (bus_word == 5'(4 + 2 * i)) bus_rdata = cfg_rd_a[i];
          if (bus_word == 5'(5 + 2 * i)) bus_rdata = cmp_rd_a[i];
        end
      end
    endcase
  end

  AST_IRQ_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_o == '0); // R1

endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  localparam int NT   = 3;
  localparam int PFS  = 10_000_000;
  localparam int PCAP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [4:0]    bus_word = '0;
  logic [63:0]   bus_wdata = '0;
  wire  [63:0]   bus_rdata;
  wire  [NT-1:0] irq_o;

  always #4 clk = ~clk;

  evt_timer #(.NUM_TMR(NT), .CNT_W(64), .PERIOD_FS(PFS), .PER_CAP(PCAP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [63:0] m_cnt;
  bit          m_run;
  bit [NT-1:0] m_sts, m_ie, m_per, m_lvl, m_f32, m_vs, m_arm, m_ph, m_pulse;
  logic [63:0] m_cmp [NT];
  logic [63:0] m_prd [NT];
  logic [63:0] nc;
  bit          up, fire;
  int          ix;

  function automatic bit hits(logic [63:0] a, logic [63:0] b, logic [63:0] c, bit narrow);
    if (narrow) return a[31:0] < c[31:0] && b[31:0] >= c[31:0];
    return a < c && b >= c;
  endfunction

  function automatic bit capable(int t);
    return ((PCAP >> t) & 1) != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_sts = 0; m_ie = 0; m_per = 0; m_lvl = 0;
      m_f32 = 0; m_vs = 0; m_arm = 0; m_ph = 0; m_pulse = 0;
      for (int t = 0; t < NT; t++) begin m_cmp[t] = 0; m_prd[t] = 0; end
    end else begin
      ix = int'(bus_word);
      nc = m_cnt; up = 0;
      if (m_run) begin nc = m_cnt + 64'd1; up = 1; end
      else if (bus_wr && ix == 3) begin nc = bus_wdata; up = 1; end
      for (int t = 0; t < NT; t++) begin
        fire = up && m_arm[t] && hits(m_cnt, nc, m_cmp[t], m_f32[t]);
        m_pulse[t] = fire && m_ie[t] && !m_lvl[t];
        if (fire) begin
          if (m_per[t]) begin
            m_cmp[t] = m_cmp[t] + m_prd[t];
            if (m_f32[t]) m_cmp[t] = m_cmp[t] & 64'hFFFF_FFFF;
          end else m_arm[t] = 0;
        end
        if (bus_wr && ix == 2 && bus_wdata[t]) m_sts[t] = 0;
        if (fire && m_lvl[t]) m_sts[t] = 1;
        if (bus_wr && ix == 4 + 2 * t) begin
          m_ie[t] = bus_wdata[0]; m_per[t] = bus_wdata[1] && capable(t);
          m_lvl[t] = bus_wdata[2]; m_f32[t] = bus_wdata[3];
          m_vs[t] = bus_wdata[4]; m_ph[t] = 0;
        end
        if (bus_wr && ix == 5 + 2 * t) begin
          logic [63:0] v;
          v = m_f32[t] ? (bus_wdata & 64'hFFFF_FFFF) : bus_wdata;
          if (!m_per[t]) begin m_cmp[t] = v; m_arm[t] = 1; end
          else if (!m_vs[t]) m_prd[t] = v;
          else if (!m_ph[t]) begin m_cmp[t] = v; m_arm[t] = 1; m_ph[t] = 1; end
          else begin m_prd[t] = v; m_ph[t] = 0; m_vs[t] = 0; end
        end
      end
      m_cnt = nc;
      if (bus_wr && ix == 1) m_run = bus_wdata[0];
    end
  end

  function automatic logic [63:0] mread(int w);
    logic [63:0] r;
    r = 0;
    case (w)
      0: r = {32'(PFS), 23'h0, 1'b1, 3'h0, 5'(NT - 1)};
      1: r = {63'h0, m_run};
      2: r = 64'(m_sts);
      3: r = m_cnt;
      default:
        for (int t = 0; t < NT; t++) begin
          if (w == 4 + 2 * t)
            r = {58'h0, capable(t), m_vs[t], m_f32[t], m_lvl[t], m_per[t], m_ie[t]};
          if (w == 5 + 2 * t) r = m_cmp[t];
        end
    endcase
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of every interrupt line (R9, R10, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int t = 0; t < NT; t++) begin
        bit e;
        e = m_lvl[t] ? (m_sts[t] && m_ie[t]) : m_pulse[t];
        chk(irq_o[t] == e, "R9_R10_irq_model", 64'(irq_o[t]), 64'(e));
      end
    end
  end

  task automatic wr(int w, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1; bus_word = 5'(w); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(int w, string tag);
    @(negedge clk);
    bus_word = 5'(w);
    #1 chk(bus_rdata === mread(w), tag, bus_rdata, mread(w));
  endtask

  task automatic rd_exp(int w, logic [63:0] exp, string tag);
    @(negedge clk);
    bus_word = 5'(w);
    #1 chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [63:0] s, e, f, saved;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R2 map
    rd_exp(0, {32'd10_000_000, 23'h0, 1'b1, 3'h0, 5'd2}, "R2_cap");
    rd_exp(1, 64'h0, "R1_gen");
    rd_exp(2, 64'h0, "R1_status");
    rd_exp(3, 64'h0, "R1_counter");
    rd_exp(4, 64'h20, "R1_cfg0");
    rd_exp(8, 64'h00, "R1_cfg2");
    chk(irq_o == 0, "R1_irq", 64'(irq_o), 64'h0);

    // R4 load while stopped, R3 hold while stopped
    wr(3, 64'd100);
    rd_exp(3, 64'd100, "R4_load_stopped");
    idle(5);
    rd_exp(3, 64'd100, "R3_hold");

    // R5 one-shot level on timer 0
    wr(4, 64'h5);
    wr(5, 64'd110);
    wr(1, 64'h1);
    rd(3, "R3_running");
    s = m_cnt;
    idle(10);
    rd_exp(3, s + 64'd11, "R3_step");
    wr(3, 64'd5);
    rd_exp(3, s + 64'd14, "R4_load_ignored");
    rd_exp(2, 64'h1, "R9_status_set");
    chk(irq_o[0] == 1'b1, "R9_irq_level", 64'(irq_o[0]), 64'h1);
    idle(4);
    chk(irq_o[0] == 1'b1, "R9_irq_held", 64'(irq_o[0]), 64'h1);
    wr(2, 64'h0);
    rd_exp(2, 64'h1, "R8_zero_no_effect");
    wr(2, 64'h1);
    rd_exp(2, 64'h0, "R8_clear");
    wr(1, 64'h0);
    wr(3, 64'd50);
    wr(1, 64'h1);
    idle(80);
    rd_exp(2, 64'h0, "R5_no_refire");

    // R10 edge one-shot on timer 1
    wr(1, 64'h0);
    wr(6, 64'h1);
    wr(7, m_cnt + 64'd20);
    wr(1, 64'h1);
    pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      #1 if (irq_o[1]) pulses++;
    end
    chk(pulses == 1, "R10_single_pulse", 64'(pulses), 64'd1);
    rd(2, "R10_no_status");

    // R6 and R7 periodic edge on timer 0
    wr(1, 64'h0);
    s = m_cnt;
    wr(4, 64'h13);
    wr(5, s + 64'd10);
    wr(5, 64'd25);
    rd_exp(4, 64'h23, "R6_vset_cleared");
    rd_exp(5, s + 64'd10, "R6_first_write_expiry");
    wr(1, 64'h1);
    idle(60);
    wr(1, 64'h0);
    f = m_cnt;
    e = s + 64'd10;
    while (e <= f) e = e + 64'd25;
    rd_exp(5, e, "R7_reload");
    saved = e;
    wr(5, 64'd7);
    rd_exp(5, saved, "R7_period_only");

    // R12 force-32 level on timer 1
    wr(3, 64'h0000_0001_FFFF_FFF0);
    wr(6, 64'hD);
    wr(7, 64'hABCD_0000_FFFF_FFF8);
    rd_exp(7, 64'h0000_0000_FFFF_FFF8, "R12_stored_32");
    wr(2, 64'h7);
    wr(1, 64'h1);
    idle(12);
    wr(1, 64'h0);
    rd_exp(2, 64'h2, "R12_low_compare");
    wr(2, 64'h2);

    // R11 masked level on timer 1
    wr(3, 64'h200);
    wr(6, 64'h4);
    wr(7, 64'h208);
    wr(1, 64'h1);
    idle(15);
    wr(1, 64'h0);
    rd(2, "R11_status_still_set");
    chk(irq_o[1] == 1'b0, "R11_irq_masked", 64'(irq_o[1]), 64'h0);
    wr(2, 64'h7);

    // R13 type bit ignored on timer 2
    wr(8, 64'h2);
    rd_exp(8, 64'h0, "R13_type_ignored");

    // R14 crossing by a load jump on timer 2
    wr(8, 64'h5);
    wr(9, 64'd5000);
    wr(3, 64'd4000);
    rd_exp(2, 64'h0, "R14_below");
    wr(3, 64'd6000);
    rd(2, "R14_status_model");
    chk(m_sts[2] == 1'b1, "R14_jump_fires_ref", 64'(m_sts[2]), 64'h1);
    chk(irq_o[2] == 1'b1, "R14_jump_irq", 64'(irq_o[2]), 64'h1);
    idle(2);

    finish_run();
  end

endmodule